// File: doc/BRIEF.md
# PCI Power-State Tracker

This block follows the PCI power-management state of a network controller and drives the internal controls that depend on it. There are five states: no power, cold sleep on auxiliary power, powered but not yet set up by the host, fully active, and hot sleep with main power still present. The block watches three asynchronous power-status inputs: the PCI reset line, auxiliary-power detect and main power-good. Each one passes through a synchroniser before the state machine uses it. The block also takes synchronous host events: a write to the 2-bit power-state field of the power-management register, carrying the PME enable bit, and a strobe that signals the host has finished configuring the device.

From the state, the block produces the power-state field readback and the PME enable bit. It also drives a fixed-length internal power-on-reset pulse, a PHY power-down level and a one-cycle PHY reset pulse. Two further outputs enable the Ethernet datapath and tell the bus logic when the device answers PCI memory and I/O accesses. A cold start on auxiliary power alone triggers the internal reset. Losing main power from a powered state leads to cold sleep when auxiliary power is present and to no power when it is absent.

Every output is registered and changes on the same edge as the state. A change on an asynchronous input shows on the outputs SYNC_STAGES+1 rising edges after the change. A synchronous host event shows one edge after it is sampled.

Top module: `pwr_state_ctrl`

## Requirements
- R1: After `rst` the state is no-power (`state_o`=0), `pm_field_o`=11b, `pme_en_o`=0, `phy_pd_o`=1, and `por_o`, `phy_rst_o`, `dp_en_o`, `pci_resp_o` are all 0. State codes are: 0 no power, 1 cold sleep, 2 powered-uninitialised, 3 active, 4 hot sleep.
- R2: In state 0, when auxiliary detect rises while power-good is low and PCI reset is asserted (`pci_rst_n_i`=0), the block enters state 1. On the same edge `por_o` rises and stays high for exactly POR_CYCLES cycles, and `pme_en_o` is cleared.
- R3: In state 1, `phy_pd_o`=1, `pm_field_o`=11b and `pci_resp_o`=0. The block leaves state 1 for state 2 only when power-good is high and PCI reset is deasserted. It returns to state 0 if auxiliary detect and power-good are both low.
- R4: In states 2 and 3, `pm_field_o`=00b and `pci_resp_o`=1. In every other state, `pm_field_o`=11b and `pci_resp_o`=0.
- R5: `dp_en_o` is 1 only in state 3.
- R6: In state 2 or 3, an accepted write of code 11b moves the block to state 4.
- R7: In state 2, a `cfg_done_i` strobe moves the block to state 3 when PCI reset is deasserted.
- R8: In states 2, 3 and 4, power-good low with auxiliary detect high moves the block to state 1. `phy_rst_o` pulses for exactly one cycle on entry, `phy_pd_o` becomes 1, and `pme_en_o` keeps its value.
- R9: In states 2, 3 and 4, power-good low with auxiliary detect low moves the block to state 0.
- R10: The transitions follow a fixed priority: total power loss, then loss of main power, then PCI reset, then a power-state write, then the configuration strobe. A write of 11b together with `cfg_done_i` in state 2 leads to state 4.
- R11: A write of code 01b or 10b is ignored entirely. Neither the state nor `pme_en_o` changes.
- R12: A write of code 00b or 11b updates `pme_en_o` from `pm_wr_pme_i`. The write is accepted only in states 2, 3 and 4 with PCI reset deasserted, and is ignored in states 0 and 1.
- R13: In state 4, an accepted write of 00b returns the block to state 2. In state 3 or 4, PCI reset assertion also returns it to state 2.
- R14: In state 0, power-good high with PCI reset deasserted moves the block directly to state 2, without a POR pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| pci_rst_n_i | input | 1 | PCI reset, active low, asynchronous |
| aux_det_i | input | 1 | Auxiliary power detect, asynchronous |
| pwr_good_i | input | 1 | Main power good, asynchronous |
| pm_wr_i | input | 1 | Host write strobe to the power-management register |
| pm_wr_code_i | input | 2 | Power-state code carried by the write |
| pm_wr_pme_i | input | 1 | PME enable value carried by the write |
| cfg_done_i | input | 1 | Host configuration-complete strobe |
| state_o | output | 3 | Current state code |
| pm_field_o | output | 2 | Power-state field readback |
| pme_en_o | output | 1 | PME enable bit |
| por_o | output | 1 | Internal power-on-reset pulse |
| phy_pd_o | output | 1 | PHY general power-down request |
| phy_rst_o | output | 1 | PHY reset pulse |
| dp_en_o | output | 1 | Ethernet transmit/receive enable |
| pci_resp_o | output | 1 | Device answers PCI accesses |

## Verification
The bench builds the block with SYNC_STAGES=3 and POR_CYCLES=6 instead of the defaults of 2 and 4. With the deeper synchroniser, the bench has to count the extra edge of latency on every power-input change before sampling the outputs. The longer reset pulse outlasts that synchroniser window, so the exact pulse width can be measured separately from the state change. Together these cover every state and the single-cycle PHY reset pulse.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;

  typedef enum logic [2:0] {
    PS_G3       = 3'd0,
    PS_D3COLD   = 3'd1,
    PS_D0UNINIT = 3'd2,
    PS_D0ACT    = 3'd3,
    PS_D3HOT    = 3'd4
  } pwr_state_e;

  localparam logic [1:0] PMF_D0 = 2'b00;
  localparam logic [1:0] PMF_D3 = 2'b11;

  // index of each asynchronous input in the synchroniser vector
  localparam int LVL_LINK_RST_N = 0;
  localparam int LVL_PGOOD      = 1;
  localparam int LVL_AUX        = 2;
  localparam int LVL_COUNT      = 3;

  function automatic logic pm_code_valid(input logic [1:0] code);
    return (code == PMF_D0) || (code == PMF_D3);
  endfunction

  function automatic logic is_powered(input pwr_state_e s);
    return (s == PS_D0UNINIT) || (s == PS_D0ACT) || (s == PS_D3HOT);
  endfunction

endpackage

// File: rtl/pwr_sync.sv
module pwr_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] level_o
);

  localparam int LAST = STAGES - 1;

  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain <= '0;
      end else begin
        chain <= {chain[STAGES-2:0], async_i[b]};
      end
    end
    assign level_o[b] = chain[LAST];
  end

endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_state_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       aux_s,
  input  logic       pgood_s,
  input  logic       link_rst_n_s,
  input  logic       pm_wr_i,
  input  logic [1:0] pm_code_i,
  input  logic       cfg_done_i,
  output pwr_state_e state_q,
  output pwr_state_e state_d,
  output logic       por_go,
  output logic       phy_rst_go,
  output logic       pm_wr_ok
);

  logic aux_prev;
  logic aux_rise;
  logic total_loss;

  assign aux_rise   = aux_s & ~aux_prev;
  assign total_loss = ~aux_s & ~pgood_s;
  assign pm_wr_ok   = pm_wr_i & pm_code_valid(pm_code_i) & link_rst_n_s
                      & is_powered(state_q);

  always_comb begin
    state_d    = state_q;
    por_go     = 1'b0;
    phy_rst_go = 1'b0;
    case (state_q)
      PS_G3: begin
        if (aux_rise && !pgood_s && !link_rst_n_s) begin
          state_d = PS_D3COLD;
          por_go  = 1'b1;
        end else if (pgood_s && link_rst_n_s) begin
          state_d = PS_D0UNINIT;
        end
      end
      PS_D3COLD: begin
        if (total_loss) begin
          state_d = PS_G3;
        end else if (pgood_s && link_rst_n_s) begin
          state_d = PS_D0UNINIT;
        end
      end
      PS_D0UNINIT, PS_D0ACT, PS_D3HOT: begin
        if (total_loss) begin
          state_d = PS_G3;
        end else if (!pgood_s) begin
          state_d    = PS_D3COLD;
          phy_rst_go = 1'b1;
        end else if (!link_rst_n_s) begin
          state_d = PS_D0UNINIT;
        end else if (state_q == PS_D3HOT) begin
          if (pm_wr_ok && pm_code_i == PMF_D0) state_d = PS_D0UNINIT;
        end else if (pm_wr_ok && pm_code_i == PMF_D3) begin
          state_d = PS_D3HOT;
        end else if (state_q == PS_D0UNINIT && cfg_done_i) begin
          state_d = PS_D0ACT;
        end
      end
      default: state_d = PS_G3;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= PS_G3;
      aux_prev <= 1'b0;
    end else begin
      state_q  <= state_d;
      aux_prev <= aux_s;
    end
  end

endmodule

// File: rtl/pwr_outputs.sv
module pwr_outputs
  import pwr_state_pkg::*;
#(
  parameter int POR_CYCLES = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  pwr_state_e state_d,
  input  logic       por_go,
  input  logic       phy_rst_go,
  input  logic       pm_wr_ok,
  input  logic       pm_wr_pme,
  output logic [1:0] pm_field_q,
  output logic       pme_en_q,
  output logic       por_q,
  output logic       phy_pd_q,
  output logic       phy_rst_q,
  output logic       dp_en_q,
  output logic       resp_q
);

  localparam int CW = $clog2(POR_CYCLES + 1);
  localparam logic [CW-1:0] POR_LOAD = CW'(POR_CYCLES - 1);

  logic [CW-1:0] por_cnt;
  logic          d0_next;

  assign d0_next = (state_d == PS_D0UNINIT) || (state_d == PS_D0ACT);

  always_ff @(posedge clk) begin
    if (rst) begin
      por_cnt <= '0;
      por_q   <= 1'b0;
    end else if (por_go) begin
      por_cnt <= POR_LOAD;
      por_q   <= 1'b1;
    end else if (por_cnt != '0) begin
      por_cnt <= por_cnt - 1'b1;
      por_q   <= 1'b1;
    end else begin
      por_q   <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pm_field_q <= PMF_D3;
      pme_en_q   <= 1'b0;
      phy_pd_q   <= 1'b1;
      phy_rst_q  <= 1'b0;
      dp_en_q    <= 1'b0;
      resp_q     <= 1'b0;
    end else begin
      pm_field_q <= d0_next ? PMF_D0 : PMF_D3;
      phy_pd_q   <= (state_d == PS_G3) || (state_d == PS_D3COLD);
      phy_rst_q  <= phy_rst_go;
      dp_en_q    <= (state_d == PS_D0ACT);
      resp_q     <= d0_next;
      if (por_go) begin
        pme_en_q <= 1'b0;
      end else if (pm_wr_ok) begin
        pme_en_q <= pm_wr_pme;
      end
    end
  end

endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int POR_CYCLES  = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pci_rst_n_i,
  input  logic       aux_det_i,
  input  logic       pwr_good_i,
  input  logic       pm_wr_i,
  input  logic [1:0] pm_wr_code_i,
  input  logic       pm_wr_pme_i,
  input  logic       cfg_done_i,
  output logic [2:0] state_o,
  output logic [1:0] pm_field_o,
  output logic       pme_en_o,
  output logic       por_o,
  output logic       phy_pd_o,
  output logic       phy_rst_o,
  output logic       dp_en_o,
  output logic       pci_resp_o
);

  logic [LVL_COUNT-1:0] lvl_async;
  logic [LVL_COUNT-1:0] lvl_sync;
  pwr_state_e           st_q;
  pwr_state_e           st_d;
  logic                 por_go;
  logic                 phy_rst_go;
  logic                 wr_ok;

  assign lvl_async[LVL_LINK_RST_N] = pci_rst_n_i;
  assign lvl_async[LVL_PGOOD]      = pwr_good_i;
  assign lvl_async[LVL_AUX]        = aux_det_i;

  pwr_sync #(.WIDTH(LVL_COUNT), .STAGES(SYNC_STAGES)) sync_i (
    .clk     (clk),
    .rst     (rst),
    .async_i (lvl_async),
    .level_o (lvl_sync)
  );

  pwr_fsm fsm_i (
    .clk          (clk),
    .rst          (rst),
    .aux_s        (lvl_sync[LVL_AUX]),
    .pgood_s      (lvl_sync[LVL_PGOOD]),
    .link_rst_n_s (lvl_sync[LVL_LINK_RST_N]),
    .pm_wr_i      (pm_wr_i),
    .pm_code_i    (pm_wr_code_i),
    .cfg_done_i   (cfg_done_i),
    .state_q      (st_q),
    .state_d      (st_d),
    .por_go       (por_go),
    .phy_rst_go   (phy_rst_go),
    .pm_wr_ok     (wr_ok)
  );

  pwr_outputs #(.POR_CYCLES(POR_CYCLES)) out_i (
    .clk        (clk),
    .rst        (rst),
    .state_d    (st_d),
    .por_go     (por_go),
    .phy_rst_go (phy_rst_go),
    .pm_wr_ok   (wr_ok),
    .pm_wr_pme  (pm_wr_pme_i),
    .pm_field_q (pm_field_o),
    .pme_en_q   (pme_en_o),
    .por_q      (por_o),
    .phy_pd_q   (phy_pd_o),
    .phy_rst_q  (phy_rst_o),
    .dp_en_q    (dp_en_o),
    .resp_q     (pci_resp_o)
  );

  assign state_o = st_q;

endmodule

// File: rtl/pwr_state_chk.sv
module pwr_state_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] state_o,
  input logic [1:0] pm_field_o,
  input logic       pme_en_o,
  input logic       por_o,
  input logic       phy_pd_o,
  input logic       phy_rst_o,
  input logic       dp_en_o,
  input logic       pci_resp_o
);

  assert_por_enters_cold_R2: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1 && $past(state_o) == 3'd0) |-> por_o);

  assert_por_clears_pme_R2: assert property (@(posedge clk) disable iff (rst)
    por_o |-> !pme_en_o);

  assert_cold_phy_down_R3: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1) |-> (phy_pd_o && !pci_resp_o && pm_field_o == 2'b11));

  assert_d0_readback_R4: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd2 || state_o == 3'd3) |-> (pci_resp_o && pm_field_o == 2'b00));

  assert_dp_only_active_R5: assert property (@(posedge clk) disable iff (rst)
    dp_en_o |-> (state_o == 3'd3));

  assert_active_from_uninit_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd3 && $past(state_o) != 3'd3) |-> ($past(state_o) == 3'd2));

  assert_phy_rst_on_loss_R8: assert property (@(posedge clk) disable iff (rst)
    (state_o == 3'd1 && $past(state_o) >= 3'd2) |-> phy_rst_o);

  assert_phy_rst_single_R8: assert property (@(posedge clk) disable iff (rst)
    phy_rst_o |=> !phy_rst_o);

endmodule

bind pwr_state_ctrl pwr_state_chk chk_i (
  .clk        (clk),
  .rst        (rst),
  .state_o    (state_o),
  .pm_field_o (pm_field_o),
  .pme_en_o   (pme_en_o),
  .por_o      (por_o),
  .phy_pd_o   (phy_pd_o),
  .phy_rst_o  (phy_rst_o),
  .dp_en_o    (dp_en_o),
  .pci_resp_o (pci_resp_o)
);

// File: tb/pwr_state_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_state_ctrl_tb_top;

  localparam int SYNC = 3;
  localparam int PORC = 6;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_n_in = 1'b0;
  logic       aux_in = 1'b0;
  logic       pg_in = 1'b0;
  logic       wr = 1'b0;
  logic [1:0] wr_code = 2'b00;
  logic       wr_pme = 1'b0;
  logic       cfg = 1'b0;
  logic [2:0] state_o;
  logic [1:0] pm_field_o;
  logic       pme_en_o, por_o, phy_pd_o, phy_rst_o, dp_en_o, pci_resp_o;

  int total = 0;
  int bad = 0;
  int exp_q[$];
  int last_state = 0;
  int por_len = 0;
  int por_pulses = 0;
  int phy_pulses = 0;
  bit phy_prev = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  pwr_state_ctrl #(.SYNC_STAGES(SYNC), .POR_CYCLES(PORC)) dut_i (
    .clk (clk), .rst (rst), .pci_rst_n_i (rst_n_in), .aux_det_i (aux_in),
    .pwr_good_i (pg_in), .pm_wr_i (wr), .pm_wr_code_i (wr_code),
    .pm_wr_pme_i (wr_pme), .cfg_done_i (cfg), .state_o (state_o),
    .pm_field_o (pm_field_o), .pme_en_o (pme_en_o), .por_o (por_o),
    .phy_pd_o (phy_pd_o), .phy_rst_o (phy_rst_o), .dp_en_o (dp_en_o),
    .pci_resp_o (pci_resp_o)
  );

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: each state change must match the next expected entry
  always @(negedge clk) begin
    if (!rst) begin
      if (int'(state_o) != last_state) begin
        total++;
        if (exp_q.size() == 0) begin
          bad++;
          $display("FAIL state-seq unexpected change actual=%0d expected=%0d", state_o, last_state);
        end else begin
          int e;
          e = exp_q.pop_front();
          if (e != int'(state_o)) begin
            bad++;
            $display("FAIL state-seq actual=%0d expected=%0d", state_o, e);
          end
        end
        last_state = int'(state_o);
      end
      if (por_o) por_len++;
      else if (por_len != 0) begin
        por_pulses++;
        check("R2 por width", por_len, PORC);
        por_len = 0;
      end
      if (phy_rst_o && !phy_prev) phy_pulses++;
      if (phy_rst_o && phy_prev) check("R8 phy_rst single cycle", 2, 1);
      phy_prev = phy_rst_o;
    end
  end

  task automatic set_power(input logic a, input logic p, input logic n);
    @(negedge clk);
    aux_in = a; pg_in = p; rst_n_in = n;
    repeat (SYNC + 3) @(negedge clk);
  endtask

  task automatic pm_write(input logic [1:0] code, input logic pme, input logic with_cfg);
    @(negedge clk);
    wr = 1'b1; wr_code = code; wr_pme = pme; cfg = with_cfg;
    @(negedge clk);
    wr = 1'b0; cfg = 1'b0;
  endtask

  task automatic cfg_strobe();
    @(negedge clk);
    cfg = 1'b1;
    @(negedge clk);
    cfg = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 state", state_o, 0);
    check("R1 pm_field", pm_field_o, 3);
    check("R1 pme", pme_en_o, 0);
    check("R1 phy_pd", phy_pd_o, 1);
    check("R1 por", por_o, 0);
    check("R1 resp+dp+phy_rst", {pci_resp_o, dp_en_o, phy_rst_o}, 0);

    // R2 cold start on auxiliary power
    exp_q.push_back(1);
    set_power(1, 0, 0);
    check("R2 state cold", state_o, 1);
    check("R2 por high", por_o, 1);
    check("R2 pme cleared", pme_en_o, 0);
    check("R3 phy_pd in cold", phy_pd_o, 1);
    check("R3 no response in cold", pci_resp_o, 0);
    repeat (8) @(negedge clk);
    check("R2 por pulse count", por_pulses, 1);

    // R12 write ignored in cold sleep
    pm_write(2'b00, 1'b1, 1'b0);
    check("R12 cold write state", state_o, 1);
    check("R12 cold write pme", pme_en_o, 0);

    // R3 power good with PCI reset still asserted: no exit
    set_power(1, 1, 0);
    check("R3 stays cold under reset", state_o, 1);

    exp_q.push_back(2);
    set_power(1, 1, 1);
    check("R3 exit to uninit", state_o, 2);
    check("R4 pm_field uninit", pm_field_o, 0);
    check("R4 resp uninit", pci_resp_o, 1);
    check("R5 dp off uninit", dp_en_o, 0);

    // R11 invalid codes ignored
    pm_write(2'b01, 1'b1, 1'b0);
    check("R11 code01 state", state_o, 2);
    check("R11 code01 pme", pme_en_o, 0);
    pm_write(2'b10, 1'b1, 1'b0);
    check("R11 code10 pme", pme_en_o, 0);

    // R12 valid write sets pme
    pm_write(2'b00, 1'b1, 1'b0);
    check("R12 pme set", pme_en_o, 1);
    check("R12 state unchanged", state_o, 2);

    // R7 configuration
    exp_q.push_back(3);
    cfg_strobe();
    check("R7 active", state_o, 3);
    check("R5 dp on active", dp_en_o, 1);
    check("R4 resp active", pci_resp_o, 1);

    // R6 hot sleep from active
    exp_q.push_back(4);
    pm_write(2'b11, 1'b1, 1'b0);
    check("R6 hot sleep", state_o, 4);
    check("R4 pm_field hot", pm_field_o, 3);
    check("R5 dp off hot", dp_en_o, 0);
    check("R4 resp off hot", pci_resp_o, 0);

    // R13 write 00 back to uninit
    exp_q.push_back(2);
    pm_write(2'b00, 1'b1, 1'b0);
    check("R13 hot to uninit", state_o, 2);

    // R10 write beats configuration strobe
    exp_q.push_back(4);
    pm_write(2'b11, 1'b1, 1'b1);
    check("R10 priority write over cfg", state_o, 4);

    // R13 PCI reset in hot sleep
    exp_q.push_back(2);
    set_power(1, 1, 0);
    check("R13 reset to uninit", state_o, 2);
    set_power(1, 1, 1);
    exp_q.push_back(3);
    cfg_strobe();
    check("R7 active again", state_o, 3);

    // R8 main power loss with aux present
    exp_q.push_back(1);
    set_power(1, 0, 1);
    check("R8 cold after loss", state_o, 1);
    check("R8 phy_rst pulses", phy_pulses, 1);
    check("R8 phy_pd", phy_pd_o, 1);
    check("R8 pme kept", pme_en_o, 1);
    check("R8 no por", por_pulses, 1);

    // R9 main power loss without aux
    exp_q.push_back(2);
    set_power(1, 1, 1);
    set_power(0, 1, 1);
    check("R9 aux removal alone", state_o, 2);
    exp_q.push_back(0);
    set_power(0, 0, 1);
    check("R9 to no power", state_o, 0);
    check("R9 pm_field", pm_field_o, 3);
    check("R9 resp", pci_resp_o, 0);

    // R14 main power only
    exp_q.push_back(2);
    set_power(0, 1, 1);
    check("R14 direct to uninit", state_o, 2);
    check("R14 no por", por_pulses, 1);

    // R2 second cold start clears pme
    exp_q.push_back(0);
    set_power(0, 0, 0);
    exp_q.push_back(1);
    set_power(1, 0, 0);
    check("R2 second cold", state_o, 1);
    check("R2 pme cleared again", pme_en_o, 0);
    repeat (8) @(negedge clk);
    check("R2 por pulse count 2", por_pulses, 2);

    // R3 aux removed in cold sleep
    exp_q.push_back(0);
    set_power(0, 0, 0);
    check("R3 cold to none", state_o, 0);

    check("scoreboard drained", exp_q.size(), 0);
    finish_run();
  end

endmodule